// File: doc/BRIEF.md
# Indexed Performance Counter Bank

This block holds a small bank of event counters that software reaches through one indexed register window. A select register chooses a counter. The assign, count-low, count-high and snapshot registers then act on that counter only. Each counter is attached to one of a set of condition inputs. While the global run bit is set, the counter adds one on every clock in which its attached condition is high. Condition number 0 never fires, and assigning it is how a single counter is stopped.

A wide counter is read without any wrap hazard by way of a snapshot. Setting the snapshot bit in the control register starts a short three-state sequence: IDLE, then CAPTURE, then RELEASE, then back to IDLE. The step out of CAPTURE copies the selected counter into a low/high snapshot pair. The step out of RELEASE clears the bit. Software may preset any counter by writing its low and high words, for example to clear it before a measurement. A read-only build word reports the counter count and the size code s, where the width is 32 + 16*s bits.

The register bus is synchronous, with a 3-bit word address. The map is: 0 select, 1 control, 2 assign, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 build. Read data is registered. The state machine has three transitions: IDLE to CAPTURE on a control write with bit 1 set, CAPTURE to RELEASE unconditionally (the capture), and RELEASE to IDLE unconditionally (the bit clears).

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, every counter, every condition assignment, the select register, the control register and both snapshot words read as zero.
- R2: When the select value is at or above the counter count, the assign, count-low and count-high registers read zero. Writes to those registers then change no counter.
- R3: While control bit 0 (run) is 1, a counter adds exactly one on each clock in which the condition input numbered by its assignment is high.
- R4: A counter holds its value while run is 0. It also holds its value while its assignment is 0, whatever the condition inputs do.
- R5: A write to count low replaces bits 31:0 of the selected counter. A write to count high replaces bits 47:32 from write-data bits 15:0. Such a write wins over an increment in the same cycle.
- R6: A counter wraps modulo 2^48, so all-ones plus one reads as zero.
- R7: Writing the control register with bit 1 set starts a snapshot. Control bit 1 reads 1 for the next two cycles, then 0. The snapshot words return the selected counter's value from the cycle after the write, and they keep it until the next snapshot.
- R8: Control bits 31:16 read back as last written. Bit 0 reads as the run state, and bits 15:2 read zero.
- R9: The build word reads valid in bit 0, the size code s = 1 in bits 7:4, and the counter count 4 in bits 15:8, which gives 0x411.
- R10: Read data appears one cycle after the address is presented. It reflects the register state before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 16 | Condition inputs; bit 0 is never counted |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default values: four 48-bit counters and sixteen conditions. At that size the index-out-of-range case is reached with a select value of 7. The 48-bit wrap is reached in a few clocks by presetting the counter to all-ones minus one. The high word's 16 live bits are exercised by the same preset. The snapshot is taken both from a stopped counter and from one that is counting. This shows that the captured value is the pre-edge count while the live counter keeps moving.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_SELECT   = 3'd0;
    localparam logic [REG_AW-1:0] A_CONTROL  = 3'd1;
    localparam logic [REG_AW-1:0] A_ASSIGN   = 3'd2;
    localparam logic [REG_AW-1:0] A_COUNT_LO = 3'd3;
    localparam logic [REG_AW-1:0] A_COUNT_HI = 3'd4;
    localparam logic [REG_AW-1:0] A_SNAP_LO  = 3'd5;
    localparam logic [REG_AW-1:0] A_SNAP_HI  = 3'd6;
    localparam logic [REG_AW-1:0] A_BUILD    = 3'd7;

    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_SNAP_BIT = 1;

    typedef enum logic [1:0] {
        SNAP_IDLE    = 2'd0,
        SNAP_CAPTURE = 2'd1,
        SNAP_RELEASE = 2'd2
    } snap_state_t;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
    parameter int W        = 48,
    parameter int NUM_COND = 16,
    parameter int COND_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [NUM_COND-1:0] ev,
    input  logic                cfg_we,
    input  logic                lo_we,
    input  logic                hi_we,
    input  logic [31:0]         wdata,
    output logic [W-1:0]        count,
    output logic [COND_W-1:0]   cond_sel,
    output logic [31:0]         rd_lo,
    output logic [31:0]         rd_hi
);
    logic          cond_ok;
    logic          hit;
    logic [W-1:0]  hi_merged;
    logic [W-1:0]  nxt;

    assign cond_ok = ({1'b0, cond_sel} < (COND_W+1)'(NUM_COND));
    assign hit     = run && (cond_sel != '0) && cond_ok && ev[cond_sel];
    assign rd_lo   = count[31:0];

    generate
        if (W > 32) begin : g_wide
            assign hi_merged = {wdata[W-33:0], count[31:0]};
            assign rd_hi     = 32'(count[W-1:32]);
        end else begin : g_narrow
            assign hi_merged = count;
            assign rd_hi     = '0;
        end
    endgenerate

    always_comb begin
        nxt = count;
        if (lo_we) begin
            nxt[31:0] = wdata;
        end else if (hi_we) begin
            nxt = hi_merged;
        end else if (hit) begin
            nxt = count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            cond_sel <= '0;
        end else begin
            count <= nxt;
            if (cfg_we) cond_sel <= wdata[COND_W-1:0];
        end
    end
endmodule

// File: rtl/pcb_snap_ctl.sv
module pcb_snap_ctl
    import pcb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic [31:0] sel_lo,
    input  logic [31:0] sel_hi,
    output logic        busy,
    output snap_state_t state_o,
    output logic [31:0] snap_lo,
    output logic [31:0] snap_hi
);
    snap_state_t state_q;
    snap_state_t state_d;
    logic        capture;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE:    if (req) state_d = SNAP_CAPTURE;
            SNAP_CAPTURE: state_d = SNAP_RELEASE;
            SNAP_RELEASE: state_d = SNAP_IDLE;
            default:      state_d = SNAP_IDLE;
        endcase
    end

    always_comb begin
        capture = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            SNAP_IDLE:    ;
            SNAP_CAPTURE: begin capture = 1'b1; busy = 1'b1; end
            SNAP_RELEASE: busy = 1'b1;
            default:      ;
        endcase
    end

    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_lo <= '0;
            snap_hi <= '0;
        end else if (capture) begin
            snap_lo <= sel_lo;
            snap_hi <= sel_hi;
        end
    end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int NUM_CTR  = 4,
    parameter int SIZE_SEL = 1,
    parameter int NUM_COND = 16,
    parameter int IDX_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_COND-1:0] ev_in,
    input  logic [2:0]          bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata
);
    localparam int CTR_W  = 32 + 16 * SIZE_SEL;
    localparam int COND_W = (NUM_COND > 1) ? $clog2(NUM_COND) : 1;

    logic [IDX_W-1:0]   sel_idx;
    logic               run_en;
    logic [15:0]        ctl_keep;
    logic               idx_ok;
    logic               wr_sel, wr_ctl, wr_cfg, wr_lo, wr_hi;
    logic [NUM_CTR-1:0] cfg_we, lo_we, hi_we;
    logic [CTR_W-1:0]   ctr_val  [NUM_CTR];
    logic [COND_W-1:0]  cond_val [NUM_CTR];
    logic [31:0]        ctr_lo   [NUM_CTR];
    logic [31:0]        ctr_hi   [NUM_CTR];
    logic [31:0]        sel_lo, sel_hi, sel_cfg;
    logic               snap_busy;
    snap_state_t        snap_state;
    logic [31:0]        snap_lo, snap_hi;
    logic [31:0]        rd_d;

    assign idx_ok = ({1'b0, sel_idx} < (IDX_W+1)'(NUM_CTR));
    assign wr_sel = bus_we && (bus_addr == A_SELECT);
    assign wr_ctl = bus_we && (bus_addr == A_CONTROL);
    assign wr_cfg = bus_we && (bus_addr == A_ASSIGN);
    assign wr_lo  = bus_we && (bus_addr == A_COUNT_LO);
    assign wr_hi  = bus_we && (bus_addr == A_COUNT_HI);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
            logic hit_sel;
            assign hit_sel    = idx_ok && (sel_idx == IDX_W'(gi));
            assign cfg_we[gi] = wr_cfg && hit_sel;
            assign lo_we[gi]  = wr_lo && hit_sel;
            assign hi_we[gi]  = wr_hi && hit_sel;

            pcb_counter #(
                .W(CTR_W), .NUM_COND(NUM_COND), .COND_W(COND_W)
            ) u_ctr (
                .clk(clk), .rst_n(rst_n), .run(run_en), .ev(ev_in),
                .cfg_we(cfg_we[gi]), .lo_we(lo_we[gi]), .hi_we(hi_we[gi]),
                .wdata(bus_wdata), .count(ctr_val[gi]), .cond_sel(cond_val[gi]),
                .rd_lo(ctr_lo[gi]), .rd_hi(ctr_hi[gi])
            );
        end
    endgenerate

    always_comb begin
        sel_lo  = '0;
        sel_hi  = '0;
        sel_cfg = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (idx_ok && (sel_idx == IDX_W'(i))) begin
                sel_lo  = ctr_lo[i];
                sel_hi  = ctr_hi[i];
                sel_cfg = 32'(cond_val[i]);
            end
        end
    end

    pcb_snap_ctl u_snap (
        .clk(clk), .rst_n(rst_n),
        .req(wr_ctl && bus_wdata[CTL_SNAP_BIT]),
        .sel_lo(sel_lo), .sel_hi(sel_hi),
        .busy(snap_busy), .state_o(snap_state),
        .snap_lo(snap_lo), .snap_hi(snap_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_idx  <= '0;
            run_en   <= 1'b0;
            ctl_keep <= '0;
        end else begin
            if (wr_sel) sel_idx <= bus_wdata[IDX_W-1:0];
            if (wr_ctl) begin
                run_en   <= bus_wdata[CTL_RUN_BIT];
                ctl_keep <= bus_wdata[31:16];
            end
        end
    end

    always_comb begin
        rd_d = '0;
        unique case (bus_addr)
            A_SELECT:   rd_d = 32'(sel_idx);
            A_CONTROL:  rd_d = {ctl_keep, 14'd0, snap_busy, run_en};
            A_ASSIGN:   rd_d = sel_cfg;
            A_COUNT_LO: rd_d = sel_lo;
            A_COUNT_HI: rd_d = sel_hi;
            A_SNAP_LO:  rd_d = snap_lo;
            A_SNAP_HI:  rd_d = snap_hi;
            A_BUILD:    rd_d = {16'd0, 8'(NUM_CTR), 4'(SIZE_SEL), 3'd0, 1'b1};
            default:    rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_d;
    end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int W       = 48,
    parameter int COND_W  = 4,
    parameter int IDX_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic [W-1:0]      cnt0,
    input logic [COND_W-1:0] cond0,
    input logic              preset0,
    input snap_state_t       snap_state,
    input logic [31:0]       snap_lo,
    input logic [2:0]        bus_addr,
    input logic [IDX_W-1:0]  sel_idx,
    input logic [31:0]       bus_rdata
);
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run) && !$past(preset0)) |-> $stable(cnt0)); // R4

    AST_HOLD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cond0) == '0) && !$past(preset0)) |-> $stable(cnt0)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(preset0) |-> ((cnt0 == $past(cnt0)) || (cnt0 == W'($past(cnt0) + 1'b1)))); // R3

    AST_SNAP_TO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_state == SNAP_CAPTURE) |=> (snap_state == SNAP_RELEASE)); // R7

    AST_SNAP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_state == SNAP_RELEASE) |=> (snap_state == SNAP_IDLE)); // R7

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((snap_state == SNAP_IDLE) && ($past(snap_state) == SNAP_IDLE)) |-> $stable(snap_lo)); // R7

    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr == A_ASSIGN) && ({1'b0, sel_idx} >= (IDX_W+1)'(NUM_CTR))) |=> (bus_rdata == '0)); // R2
endmodule

bind perf_counter_bank pcb_checker #(
    .NUM_CTR(NUM_CTR), .W(CTR_W), .COND_W(COND_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_en),
    .cnt0(ctr_val[0]), .cond0(cond_val[0]), .preset0(lo_we[0] | hi_we[0]),
    .snap_state(snap_state), .snap_lo(snap_lo),
    .bus_addr(bus_addr), .sel_idx(sel_idx), .bus_rdata(bus_rdata)
);

// File: tb/sim_perf_counter_bank.sv
module sim_perf_counter_bank;
    localparam int N = 4;
    localparam logic [63:0] MASK = (64'd1 << 48) - 64'd1;
    localparam logic [2:0] SEL = 0, CTL = 1, CFG = 2, LO = 3, HI = 4, SLO = 5, SHI = 6, BLD = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev = '0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [63:0] m_cnt [N];
    int          m_cond [N];
    int          m_idx;
    logic        m_en;
    logic [15:0] m_keep;
    logic [63:0] m_snap;
    int          m_st;
    logic [31:0] exp_rd;

    always #4 clk = ~clk;

    perf_counter_bank u0 (
        .clk(clk), .rst_n(rst_n), .ev_in(ev), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata)
    );

    function automatic logic [31:0] m_read(logic [2:0] a);
        logic ok;
        ok = (m_idx < N);
        case (a)
            SEL: return 32'(m_idx);
            CTL: return {m_keep, 14'd0, (m_st != 0), m_en};
            CFG: return ok ? 32'(m_cond[m_idx]) : 32'd0;
            LO:  return ok ? m_cnt[m_idx][31:0] : 32'd0;
            HI:  return ok ? m_cnt[m_idx][63:32] : 32'd0;
            SLO: return m_snap[31:0];
            SHI: return m_snap[63:32];
            default: return 32'h411;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_cnt[i] = '0; m_cond[i] = 0; end
            m_idx = 0; m_en = 0; m_keep = '0; m_snap = '0; m_st = 0; exp_rd = '0;
        end else begin
            exp_rd = m_read(addr); // R10: value before this edge
            if (m_st == 1) begin
                m_snap = (m_idx < N) ? m_cnt[m_idx] : 64'd0;
                m_st = 2;
            end else if (m_st == 2) begin
                m_st = 0;
            end
            for (int i = 0; i < N; i++) begin
                logic pre_lo, pre_hi, inc;
                pre_lo = we && addr == LO && m_idx == i;
                pre_hi = we && addr == HI && m_idx == i;
                inc = m_en && m_cond[i] != 0 && ev[m_cond[i]];
                if (pre_lo) m_cnt[i] = {m_cnt[i][63:32], wdata};
                else if (pre_hi) m_cnt[i] = {16'd0, wdata[15:0], m_cnt[i][31:0]};
                else if (inc) m_cnt[i] = (m_cnt[i] + 64'd1) & MASK;
            end
            if (we) begin
                case (addr)
                    SEL: m_idx = int'(wdata[7:0]);
                    CTL: begin
                        m_en = wdata[0];
                        m_keep = wdata[31:16];
                        if (wdata[1] && m_st == 0) m_st = 1;
                    end
                    CFG: if (m_idx < N) m_cond[m_idx] = int'(wdata[3:0]);
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s per-cycle rdata actual %h expected %h", cur_req, rdata, exp_rd);
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        addr = a; we = 1'b0;
        @(posedge clk); @(negedge clk);
        d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic run_tests();
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R9";
        rd(BLD, v); chk("R9 R10 build word", v, 32'h411);
        cur_req = "R1";
        rd(CTL, v); chk("R1 control", v, 0);
        rd(LO, v);  chk("R1 count", v, 0);
        rd(SLO, v); chk("R1 snapshot", v, 0);

        cur_req = "R3";
        wr(SEL, 1); wr(CFG, 3); wr(CTL, 1);
        ev = 16'h0008; idle(10); ev = '0;
        wr(CTL, 0);
        rd(LO, v);  chk("R3 ten counts", v, 10);
        rd(CFG, v); chk("R3 assignment", v, 3);

        cur_req = "R4";
        ev = 16'hFFFF; idle(5);
        rd(LO, v); chk("R4 run off holds", v, 10);
        ev = '0;
        wr(SEL, 2); wr(CFG, 0); wr(CTL, 1);
        ev = 16'hFFFF; idle(6); ev = '0;
        wr(CTL, 0);
        rd(LO, v); chk("R4 condition 0 never", v, 0);

        cur_req = "R6";
        wr(SEL, 1); wr(HI, 32'hFFFF); wr(LO, 32'hFFFF_FFFE);
        rd(HI, v); chk("R6 preset high", v, 32'hFFFF);
        wr(CTL, 1); ev = 16'h0008; idle(3); ev = '0;
        wr(CTL, 0);
        rd(LO, v); chk("R6 wrap low", v, 1);
        rd(HI, v); chk("R6 wrap high", v, 0);

        cur_req = "R5";
        wr(CTL, 1); ev = 16'h0008;
        wr(LO, 32'h100);
        wr(CTL, 0); ev = '0;
        rd(LO, v); chk("R5 preset wins then counts", v, 32'h101);

        cur_req = "R2";
        wr(SEL, 7); wr(CFG, 5); wr(LO, 32'h55); wr(HI, 32'h66);
        rd(CFG, v); chk("R2 assign reads zero", v, 0);
        rd(LO, v);  chk("R2 low reads zero", v, 0);
        rd(HI, v);  chk("R2 high reads zero", v, 0);
        rd(SEL, v); chk("R2 select readback", v, 7);
        wr(SEL, 0);
        rd(LO, v);  chk("R2 counter 0 untouched", v, 0);
        rd(CFG, v); chk("R2 assign 0 untouched", v, 0);
        wr(SEL, 1);
        rd(LO, v);  chk("R2 counter 1 untouched", v, 32'h101);

        cur_req = "R7";
        wr(HI, 32'h1234); wr(LO, 32'h42);
        wr(CTL, 32'hABCD_0002);
        rd(CTL, v); chk("R7 R8 busy first cycle", v, 32'hABCD_0002);
        rd(CTL, v); chk("R7 R8 busy second cycle", v, 32'hABCD_0002);
        rd(CTL, v); chk("R7 R8 bit cleared", v, 32'hABCD_0000);
        rd(SHI, v); chk("R7 snapshot high", v, 32'h1234);
        rd(SLO, v); chk("R7 snapshot low", v, 32'h42);
        wr(LO, 0);
        rd(SLO, v); chk("R7 snapshot held", v, 32'h42);

        cur_req = "R8";
        rd(CTL, v); chk("R8 upper bits kept", v, 32'hABCD_0000);
        wr(CTL, 32'h5A5A_FFFD);
        rd(CTL, v); chk("R8 run set, middle zero", v, 32'h5A5A_0001);
        wr(CTL, 0);

        cur_req = "R7";
        wr(HI, 0); wr(LO, 5);
        wr(CTL, 3); ev = 16'h0008; idle(4); ev = '0;
        wr(CTL, 0);
        rd(SLO, v); chk("R7 snapshot while counting", v, 5);
        rd(LO, v);  chk("R7 live counter moved on", v, 9);
        idle(2);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule